// File: doc/BRIEF.md
# Command Buffer Fetch Controller

This block is the control front end of a 2D blit engine. A host programs it through a small register port with one-cycle write and read strobes. It stores a memory address for a command list, a master-mode enable bit, interrupt enable and mask words, and a pending-event word. A start pulse makes the block fetch a fixed-length block of 32-bit command words from memory through a 32-bit read master. It places word n in a command register that the host can read at byte offset 0x100 + 4n.

When the last word has landed, the block tells the datapath to run with a one-cycle pulse. It waits for the datapath to report completion and then records a frame-done event. A read error response ends the fetch early and records a read-fault event. The datapath does not run after a read fault. A level interrupt output is high while any pending event is both enabled and not masked. Two soft-reset bits in the system word return the engine to idle.

Top module: `cmdfetch_ctrl`

## Requirements
- R1: After reset the engine state reads 0 (idle), the pending, enable and mask words read 0, the master bit reads 0 and `irq` is low.
- R2: A read strobe at `reg_addr` loads `reg_rdata` on the next clock edge, and the value holds until the next read. The map is: 0x000 system word (bit 1 master mode, bits 3 and 4 soft reset, which read 0); 0x004 command control (bit 0 start, reads 0); 0x008 command list address; 0x018 version with the major number in [31:28], the minor number in [27:20] and 0 elsewhere; 0x020 enable; 0x024 pending; 0x028 mask; 0x02C clear (reads 0); 0x040 engine state (0 idle, 1 fetching, 2 running).
- R3: A start while idle with master mode set issues NWORDS reads, one at a time, at address A + 4n for n = 0 to NWORDS-1, where A is the programmed list address. Each request keeps `mrd_req_valid` and its address steady until `mrd_req_ready`.
- R4: Response n is readable at offset 0x100 + 4n. After the last good response, `dp_start` pulses for exactly one cycle and the state becomes 2.
- R5: `dp_done` while running returns the state to 0 and sets pending bit 0.
- R6: Writing ones to 0x02C clears the matching pending bits. An event arriving in the same cycle as the clear still leaves its bit set.
- R7: An error response during a fetch sets pending bit 2, returns the state to 0 and gives no `dp_start`.
- R8: `dp_wr_err` sets pending bit 15 in any state.
- R9: `irq` is high exactly when some pending bit is set, its enable bit is 1 and its mask bit is 0.
- R10: A start is ignored while the state is fetching or running, and also when master mode is clear. An ignored start issues no request and gives no `dp_start`.
- R11: A write to 0x000 with bit 3 or bit 4 set returns the engine to idle, drops the request in progress and gives no `dp_start`. A response that arrives later is ignored.
- R12: `dp_done` outside the running state changes neither the state nor the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mrd_req_valid | output | 1 | Read request valid |
| mrd_req_ready | input | 1 | Read request accepted |
| mrd_req_addr | output | 32 | Read byte address |
| mrd_rsp_valid | input | 1 | Read response valid |
| mrd_rsp_data | input | 32 | Read response word |
| mrd_rsp_err | input | 1 | Read response carries an error |
| dp_start | output | 1 | One-cycle run pulse to the datapath |
| dp_done | input | 1 | Datapath finished the frame |
| dp_wr_err | input | 1 | Datapath write-bus fault |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is an event and a host clear of the same pending bit landing in the same clock. The bench gets there by driving the `dp_wr_err` pulse and the clear write from one task in the same half cycle. It then reads back the pending word. A second hard case is a response that arrives after a soft reset has dropped its fetch. The memory model keeps a programmable latency, so that response arrives while the engine is idle. The bench then checks that the engine stays idle and that a fresh fetch still runs cleanly.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_ISSUE = 2'd1,
    FS_WAIT  = 2'd2,
    FS_RUN   = 2'd3
  } fetch_fsm_t;

  localparam logic [1:0] ENG_IDLE  = 2'd0;
  localparam logic [1:0] ENG_FETCH = 2'd1;
  localparam logic [1:0] ENG_RUN   = 2'd2;

  localparam int OFS_SYS   = 'h000;
  localparam int OFS_CMD   = 'h004;
  localparam int OFS_BASE  = 'h008;
  localparam int OFS_VER   = 'h018;
  localparam int OFS_EN    = 'h020;
  localparam int OFS_RAW   = 'h024;
  localparam int OFS_MSK   = 'h028;
  localparam int OFS_CLR   = 'h02C;
  localparam int OFS_STATE = 'h040;
  localparam int OFS_WORDS = 'h100;

  localparam int BIT_MASTER = 1;
  localparam int BIT_SRST_A = 3;
  localparam int BIT_SRST_C = 4;
  localparam int IRQ_DONE   = 0;
  localparam int IRQ_RDERR  = 2;
  localparam int IRQ_WRERR  = 15;

  function automatic logic [1:0] eng_code(fetch_fsm_t s);
    case (s)
      FS_IDLE: return ENG_IDLE;
      FS_RUN:  return ENG_RUN;
      default: return ENG_FETCH;
    endcase
  endfunction

  function automatic logic [31:0] next_word_addr(logic [31:0] a);
    return a + 32'd4;
  endfunction

  function automatic logic [31:0] version_word(logic [3:0] maj, logic [7:0] minr);
    return {maj, minr, 20'd0};
  endfunction

  function automatic logic irq_level(logic [31:0] raw, logic [31:0] en, logic [31:0] msk);
    return |(raw & en & ~msk);
  endfunction

endpackage

// File: rtl/cfc_cmdstore.sv
module cfc_cmdstore #(
  parameter int NWORDS = 46,
  parameter int IDXW   = $clog2(NWORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [IDXW-1:0] widx,
  input  logic [31:0]     wdata,
  input  logic [IDXW-1:0] ridx,
  output logic [31:0]     rdata
);
  logic [NWORDS*32-1:0] flat;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [31:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (wr && widx == IDXW'(g))     q <= wdata;
    end
    assign flat[g*32 +: 32] = q;
  end

  assign rdata = (ridx < IDXW'(NWORDS)) ? flat[ridx*32 +: 32] : 32'd0;
endmodule

// File: rtl/cfc_irq.sv
module cfc_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_wr,
  input  logic        msk_wr,
  input  logic        clr_wr,
  input  logic [31:0] wdata,
  input  logic [31:0] set_vec,
  output logic [31:0] raw,
  output logic [31:0] en,
  output logic [31:0] msk,
  output logic        irq
);
  import cfc_pkg::*;

  logic [31:0] clr_vec;
  assign clr_vec = clr_wr ? wdata : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= '0;
      en  <= '0;
      msk <= '0;
    end else begin
      raw <= (raw & ~clr_vec) | set_vec;
      if (en_wr)  en  <= wdata;
      if (msk_wr) msk <= wdata;
    end
  end

  assign irq = irq_level(raw, en, msk);
endmodule

// File: rtl/cfc_fetch.sv
module cfc_fetch #(
  parameter int NWORDS = 46,
  parameter int IDXW   = $clog2(NWORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_req,
  input  logic            master,
  input  logic            soft_rst,
  input  logic [31:0]     base,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [31:0]     req_addr,
  input  logic            rsp_valid,
  input  logic [31:0]     rsp_data,
  input  logic            rsp_err,
  output logic            dp_start,
  input  logic            dp_done,
  output logic            start_go,
  output logic            st_wr,
  output logic [IDXW-1:0] st_idx,
  output logic [31:0]     st_data,
  output logic            done_evt,
  output logic            rderr_evt,
  output logic [1:0]      eng_state
);
  import cfc_pkg::*;

  fetch_fsm_t fsm;
  logic [IDXW-1:0] idx;
  logic last_word;

  assign last_word = (idx == IDXW'(NWORDS - 1));
  assign start_go  = start_req && master && fsm == FS_IDLE && !soft_rst;
  assign st_wr     = fsm == FS_WAIT && rsp_valid && !rsp_err && !soft_rst;
  assign rderr_evt = fsm == FS_WAIT && rsp_valid && rsp_err && !soft_rst;
  assign done_evt  = fsm == FS_RUN && dp_done && !soft_rst;
  assign st_idx    = idx;
  assign st_data   = rsp_data;
  assign eng_state = eng_code(fsm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm       <= FS_IDLE;
      req_valid <= 1'b0;
      req_addr  <= '0;
      idx       <= '0;
      dp_start  <= 1'b0;
    end else begin
      dp_start <= 1'b0;
      if (soft_rst) begin
        fsm       <= FS_IDLE;
        req_valid <= 1'b0;
      end else begin
        case (fsm)
          FS_IDLE: if (start_go) begin
            fsm       <= FS_ISSUE;
            req_valid <= 1'b1;
            req_addr  <= base;
            idx       <= '0;
          end
          FS_ISSUE: if (req_ready) begin
            req_valid <= 1'b0;
            fsm       <= FS_WAIT;
          end
          FS_WAIT: if (rsp_valid) begin
            if (rsp_err) begin
              fsm <= FS_IDLE;
            end else if (last_word) begin
              fsm      <= FS_RUN;
              dp_start <= 1'b1;
            end else begin
              idx       <= idx + 1'b1;
              req_addr  <= next_word_addr(req_addr);
              req_valid <= 1'b1;
              fsm       <= FS_ISSUE;
            end
          end
          FS_RUN: if (dp_done) fsm <= FS_IDLE;
          default: fsm <= FS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmdfetch_ctrl.sv
module cmdfetch_ctrl #(
  parameter int          AW        = 10,
  parameter int          NWORDS    = 46,
  parameter logic [3:0]  VER_MAJOR = 4'd3,
  parameter logic [7:0]  VER_MINOR = 8'h5C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mrd_req_valid,
  input  logic          mrd_req_ready,
  output logic [31:0]   mrd_req_addr,
  input  logic          mrd_rsp_valid,
  input  logic [31:0]   mrd_rsp_data,
  input  logic          mrd_rsp_err,
  output logic          dp_start,
  input  logic          dp_done,
  input  logic          dp_wr_err,
  output logic          irq
);
  import cfc_pkg::*;

  localparam int IDXW = $clog2(NWORDS);
  localparam logic [AW-1:0] A_SYS   = AW'(OFS_SYS);
  localparam logic [AW-1:0] A_CMD   = AW'(OFS_CMD);
  localparam logic [AW-1:0] A_BASE  = AW'(OFS_BASE);
  localparam logic [AW-1:0] A_VER   = AW'(OFS_VER);
  localparam logic [AW-1:0] A_EN    = AW'(OFS_EN);
  localparam logic [AW-1:0] A_RAW   = AW'(OFS_RAW);
  localparam logic [AW-1:0] A_MSK   = AW'(OFS_MSK);
  localparam logic [AW-1:0] A_STATE = AW'(OFS_STATE);
  localparam logic [AW-1:0] A_WORDS = AW'(OFS_WORDS);
  localparam logic [AW-1:0] A_SPAN  = AW'(NWORDS * 4);
  localparam logic [AW-1:0] A_CLR   = AW'(OFS_CLR);

  logic            master;
  logic [31:0]     base;
  logic            soft_rst, start_req, start_go;
  logic            st_wr, done_evt, rderr_evt;
  logic [IDXW-1:0] st_idx, ridx;
  logic [31:0]     st_data, word_rd;
  logic [1:0]      eng_state;
  logic [31:0]     raw, en, msk, set_vec, rd_mux;
  logic            clr_wr;
  logic [AW-1:0]   rel;
  logic            word_hit;

  assign soft_rst  = reg_wr && reg_addr == A_SYS &&
                     (reg_wdata[BIT_SRST_A] || reg_wdata[BIT_SRST_C]);
  assign start_req = reg_wr && reg_addr == A_CMD && reg_wdata[0];
  assign clr_wr    = reg_wr && reg_addr == A_CLR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master <= 1'b0;
      base   <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_SYS)  master <= reg_wdata[BIT_MASTER];
      if (reg_addr == A_BASE) base   <= reg_wdata;
    end
  end

  cfc_fetch #(.NWORDS(NWORDS), .IDXW(IDXW)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .start_req(start_req), .master(master), .soft_rst(soft_rst), .base(base),
    .req_valid(mrd_req_valid), .req_ready(mrd_req_ready), .req_addr(mrd_req_addr),
    .rsp_valid(mrd_rsp_valid), .rsp_data(mrd_rsp_data), .rsp_err(mrd_rsp_err),
    .dp_start(dp_start), .dp_done(dp_done),
    .start_go(start_go), .st_wr(st_wr), .st_idx(st_idx), .st_data(st_data),
    .done_evt(done_evt), .rderr_evt(rderr_evt), .eng_state(eng_state)
  );

  assign rel      = reg_addr - A_WORDS;
  assign word_hit = reg_addr >= A_WORDS && rel < A_SPAN;
  assign ridx     = rel[IDXW+1:2];

  cfc_cmdstore #(.NWORDS(NWORDS), .IDXW(IDXW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr(st_wr), .widx(st_idx), .wdata(st_data),
    .ridx(ridx), .rdata(word_rd)
  );

  always_comb begin
    set_vec = '0;
    set_vec[IRQ_DONE]  = done_evt;
    set_vec[IRQ_RDERR] = rderr_evt;
    set_vec[IRQ_WRERR] = dp_wr_err;
  end

  cfc_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .en_wr(reg_wr && reg_addr == A_EN),
    .msk_wr(reg_wr && reg_addr == A_MSK),
    .clr_wr(clr_wr), .wdata(reg_wdata), .set_vec(set_vec),
    .raw(raw), .en(en), .msk(msk), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (word_hit) begin
      rd_mux = word_rd;
    end else begin
      case (reg_addr)
        A_SYS:   rd_mux[BIT_MASTER] = master;
        A_BASE:  rd_mux = base;
        A_VER:   rd_mux = version_word(VER_MAJOR, VER_MINOR);
        A_EN:    rd_mux = en;
        A_RAW:   rd_mux = raw;
        A_MSK:   rd_mux = msk;
        A_STATE: rd_mux = {30'd0, eng_state};
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic        dp_start,
  input logic        dp_done,
  input logic        soft_rst,
  input logic        start_go,
  input logic [1:0]  eng_state,
  input logic        clr_wr,
  input logic [31:0] clr_data,
  input logic [31:0] set_vec,
  input logic [31:0] raw
);
  import cfc_pkg::*;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !soft_rst |=> req_valid && $stable(req_addr)); // R3
  AST_REQ_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> eng_state == ENG_FETCH); // R3
  AST_RUN_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    dp_start |-> $past(rsp_valid && !rsp_err)); // R4
  AST_RUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dp_start |=> !dp_start); // R4
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    eng_state == ENG_FETCH && !req_valid && rsp_valid && rsp_err
    |=> eng_state == ENG_IDLE && !dp_start); // R7
  AST_IDLE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    eng_state == ENG_IDLE && !start_go |=> eng_state == ENG_IDLE); // R10
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_state == ENG_RUN && !dp_done && !soft_rst |=> eng_state == ENG_RUN); // R10
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && clr_data == 32'hFFFF_FFFF && set_vec == 32'd0 |=> raw == 32'd0); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[IRQ_DONE] |=> raw[IRQ_DONE]); // R5
  AST_SOFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> eng_state == ENG_IDLE && !req_valid && !dp_start); // R11
endmodule

bind cmdfetch_ctrl cfc_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(mrd_req_valid), .req_ready(mrd_req_ready), .req_addr(mrd_req_addr),
  .rsp_valid(mrd_rsp_valid), .rsp_err(mrd_rsp_err),
  .dp_start(dp_start), .dp_done(dp_done), .soft_rst(soft_rst), .start_go(start_go),
  .eng_state(eng_state), .clr_wr(clr_wr), .clr_data(reg_wdata),
  .set_vec(set_vec), .raw(raw)
);

// File: tb/test_cmdfetch_ctrl.sv
`timescale 1ns/1ps
module test_cmdfetch_ctrl;
  localparam int AW = 10;
  localparam int N  = 46;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic          mrd_req_valid, mrd_req_ready;
  logic [31:0]   mrd_req_addr;
  logic          mrd_rsp_valid, mrd_rsp_err;
  logic [31:0]   mrd_rsp_data;
  logic          dp_start, dp_done = 1'b0, dp_wr_err = 1'b0, irq;

  int checks = 0, errors = 0;
  int n_req = 0, n_dps = 0, cyc = 0;
  int stall = 0, lat_cfg = 0;
  bit err_on = 0;
  logic [31:0] err_addr = '0;

  always #2 clk = ~clk;

  cmdfetch_ctrl #(.AW(AW), .NWORDS(N)) i_cmdfetch_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mrd_req_valid(mrd_req_valid), .mrd_req_ready(mrd_req_ready), .mrd_req_addr(mrd_req_addr),
    .mrd_rsp_valid(mrd_rsp_valid), .mrd_rsp_data(mrd_rsp_data), .mrd_rsp_err(mrd_rsp_err),
    .dp_start(dp_start), .dp_done(dp_done), .dp_wr_err(dp_wr_err), .irq(irq)
  );

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  // memory model and event counters, all at the falling edge
  initial begin
    bit pend = 0;
    int lat = 0;
    logic [31:0] paddr = '0;
    mrd_req_ready = 1'b0; mrd_rsp_valid = 1'b0; mrd_rsp_err = 1'b0; mrd_rsp_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (dp_start) n_dps++;
      mrd_rsp_valid = 1'b0; mrd_rsp_err = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mrd_rsp_valid = 1'b1;
          mrd_rsp_data  = mem_word(paddr);
          mrd_rsp_err   = err_on && paddr == err_addr;
          pend = 0;
        end else lat--;
      end
      mrd_req_ready = (stall == 0) ? 1'b1 : (cyc % stall != 0);
      if (mrd_req_valid && mrd_req_ready && !pend) begin
        pend = 1; paddr = mrd_req_addr; lat = lat_cfg; n_req++;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); dp_done = 1'b1;
    @(negedge clk); dp_done = 1'b0;
  endtask

  task automatic wait_state(logic [1:0] st);
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(10'h040, v);
      if (v[1:0] == st) return;
    end
  endtask

  task automatic run_job(logic [31:0] base, int st, int lt, string tag);
    logic [31:0] v;
    int r0 = n_req, d0 = n_dps;
    stall = st; lat_cfg = lt;
    wr(10'h008, base);
    wr(10'h004, 32'h1);
    rd(10'h040, v); chk({tag, " R3 state fetching"}, v, 32'd1);
    wait_state(2'd2);
    chk({tag, " R3 request count"}, n_req - r0, N);
    chk({tag, " R4 one run pulse"}, n_dps - d0, 1);
    for (int k = 0; k < N; k++) begin
      rd(AW'(10'h100 + 4 * k), v);
      chk({tag, " R4 command word"}, v, mem_word(base + 32'(4 * k)));
    end
  endtask

  initial begin
    logic [31:0] v;
    int r0, d0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(10'h040, v); chk("R1 state", v, 32'd0);
    rd(10'h024, v); chk("R1 pending", v, 32'd0);
    rd(10'h020, v); chk("R1 enable", v, 32'd0);
    rd(10'h028, v); chk("R1 mask", v, 32'd0);
    rd(10'h000, v); chk("R1 master", v, 32'd0);
    chk("R1 irq", irq, 32'd0);
    // R2 map details
    rd(10'h018, v); chk("R2 version", v, {4'd3, 8'h5C, 20'd0});
    wr(10'h008, 32'hCAFE_0100);
    rd(10'h008, v); chk("R2 address word", v, 32'hCAFE_0100);
    rd(10'h004, v); chk("R2 start reads 0", v, 32'd0);
    rd(10'h02C, v); chk("R2 clear reads 0", v, 32'd0);
    // R10 start with master clear
    r0 = n_req;
    wr(10'h004, 32'h1);
    repeat (5) @(negedge clk);
    rd(10'h040, v); chk("R10 no master state", v, 32'd0);
    chk("R10 no master requests", n_req - r0, 0);
    wr(10'h000, 32'h2);
    rd(10'h000, v); chk("R2 master bit", v, 32'h2);
    wr(10'h020, 32'h0000_8005);
    // sweep of handshake timing
    for (int m = 0; m < 4; m++) begin
      run_job(32'h0001_0000 + 32'(m * 32'h340), (m == 0) ? 0 : m + 1, m, "sweep");
      r0 = n_req; d0 = n_dps;
      wr(10'h004, 32'h1); // R10 start while running
      repeat (4) @(negedge clk);
      rd(10'h040, v); chk("R10 busy start state", v, 32'd2);
      chk("R10 busy start requests", n_req - r0, 0);
      chk("R10 busy start pulse", n_dps - d0, 0);
      chk("R9 no irq yet", irq, 32'd0);
      pulse_done();
      rd(10'h040, v); chk("R5 idle after done", v, 32'd0);
      rd(10'h024, v); chk("R5 done pending", v, 32'h1);
      chk("R9 irq enabled", irq, 32'd1);
      wr(10'h028, 32'h1);
      chk("R9 irq masked", irq, 32'd0);
      wr(10'h028, 32'h0);
      wr(10'h02C, 32'hFFFF_FFFF);
      rd(10'h024, v); chk("R6 cleared", v, 32'd0);
      chk("R9 irq after clear", irq, 32'd0);
    end
    // R12 done while idle
    pulse_done();
    rd(10'h024, v); chk("R12 pending unchanged", v, 32'd0);
    rd(10'h040, v); chk("R12 state unchanged", v, 32'd0);
    // R7 read error at word 7
    err_on = 1; err_addr = 32'h0002_0000 + 32'd28; stall = 2; lat_cfg = 1;
    d0 = n_dps; r0 = n_req;
    wr(10'h008, 32'h0002_0000);
    wr(10'h004, 32'h1);
    wait_state(2'd0);
    repeat (10) @(negedge clk);
    rd(10'h024, v); chk("R7 read fault pending", v, 32'h4);
    chk("R7 no run pulse", n_dps - d0, 0);
    chk("R7 stopped at faulty word", n_req - r0, 8);
    chk("R9 irq on fault", irq, 32'd1);
    rd(10'h100, v); chk("R7 earlier word", v, mem_word(32'h0002_0000));
    err_on = 0;
    wr(10'h02C, 32'h4);
    // R11 soft reset during fetch, late response
    for (int b = 3; b <= 4; b++) begin
      stall = 0; lat_cfg = 6; d0 = n_dps;
      wr(10'h008, 32'h0003_0000);
      wr(10'h004, 32'h1);
      repeat (3) @(negedge clk);
      wr(10'h000, 32'h2 | (32'h1 << b));
      rd(10'h040, v); chk("R11 idle after soft reset", v, 32'd0);
      repeat (20) @(negedge clk);
      rd(10'h040, v); chk("R11 still idle", v, 32'd0);
      chk("R11 no run pulse", n_dps - d0, 0);
      rd(10'h000, v); chk("R11 soft bits read 0", v, 32'h2);
    end
    run_job(32'h0004_0000, 0, 0, "after soft reset");
    pulse_done();
    wr(10'h02C, 32'h1);
    // R8 write fault, and R6 event beating a same-cycle clear
    @(negedge clk); dp_wr_err = 1'b1;
    @(negedge clk); dp_wr_err = 1'b0;
    rd(10'h024, v); chk("R8 write fault pending", v, 32'h8000);
    chk("R9 irq write fault", irq, 32'd1);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 10'h02C; reg_wdata = 32'h8000; dp_wr_err = 1'b1;
    @(negedge clk); reg_wr = 1'b0; dp_wr_err = 1'b0;
    rd(10'h024, v); chk("R6 set beats clear", v, 32'h8000);
    wr(10'h02C, 32'h8000);
    rd(10'h024, v); chk("R6 clear single bit", v, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule